// File: doc/BRIEF.md
# Straddled Completion Segment Decoder

This block sits on the receive side of a 512-bit completion stream in which a single beat may hold pieces of up to four packets. It does not look at payload. For each accepted beat it reads the start-flag vector, the end-flag vector and their position pointers. From these it produces an ordered list of up to four segment descriptors. Each descriptor gives the first Dword index, the last Dword index, and whether the segment opens and/or closes a packet.

A packet that starts in one beat and does not end there stays open. The next beat then begins with a continuation segment that starts at Dword 0. A downstream reassembly stage can copy Dword ranges straight from the descriptors without decoding the flags again. The block raises a sticky error when the flags break the protocol. Input and output both use a valid/ready handshake. The output is one registered descriptor bundle per input beat.

Top module: `cpl_seg_decoder`

## Requirements
- R1: A beat is accepted only when in_valid and in_ready are both high. in_ready is high whenever the output register is empty or is being drained in the same cycle. The descriptor bundle for an accepted beat appears on the outputs with out_valid high in the following cycle.
- R2: While out_valid is high and out_ready is low, all descriptor outputs hold their values and in_ready is low.
- R3: seg_mask is contiguous from bit 0. The number of set bits equals the count of starts in the beat, plus one if a packet was open when the beat arrived.
- R4: The start flags use thermometer codes (0000, 0001, 0011, 0111, 1111). The 2-bit start pointer i sits at in_sop_ptr[2i+1:2i], and codes 0 to 3 map to Dword 0, 4, 8 and 12. A segment opened by start i reports that Dword as its first index and sets its seg_sop bit.
- R5: The end flags use the same thermometer code. Segment k is closed by end slot k, whose 4-bit pointer sits at in_eop_ptr[4k+3:4k]. A closed segment sets seg_eop[k] and reports the pointer as its last index. A segment in the mask that is not closed reports last index 15 with seg_eop clear. Fields at positions outside the mask read 0. Descriptor field k is at bits [4k+3:4k] of seg_first and seg_last.
- R6: When a packet is open on arrival, segment 0 starts at Dword 0 with seg_sop[0] clear. A beat with no flags during an open packet yields one segment spanning Dwords 0 to 15 with neither flag set, and the packet stays open.
- R7: A start or end flag vector that is not a thermometer code sets proto_err.
- R8: A start pointer whose value is below its own slot index (slot 1 at 0, slot 2 at 0 or 1, slot 3 below 3) sets proto_err.
- R9: A segment that has both a start and an end, with its end pointer below its first Dword, sets proto_err.
- R10: A start that follows a still-open packet with no end before it sets proto_err. This covers a new start during an open packet with no ends in the beat.
- R11: proto_err is cleared only by reset and stays high once set. Legal traffic never sets it. Reset clears out_valid, proto_err and the open-packet state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block can take a beat |
| in_sop_flags | input | 4 | Start flags, thermometer code |
| in_sop_ptr | input | 8 | Four 2-bit start lane pointers |
| in_eop_flags | input | 4 | End flags, thermometer code |
| in_eop_ptr | input | 16 | Four 4-bit last-Dword pointers |
| out_valid | output | 1 | Descriptor bundle valid |
| out_ready | input | 1 | Consumer takes the bundle |
| seg_mask | output | 4 | Segment valid mask |
| seg_first | output | 16 | First Dword index of each segment |
| seg_last | output | 16 | Last Dword index of each segment |
| seg_sop | output | 4 | Segment starts a packet |
| seg_eop | output | 4 | Segment ends a packet |
| proto_err | output | 1 | Sticky protocol error |

## Verification
The hardest case to reach is a beat that starts with a continuation segment and also carries further starts. In that case the start slots pair with end slots shifted by one, and the last new packet is left open. The stimulus gets there in three steps. First it opens a packet at Dword 8. Then it sends a flagless middle beat. Then it sends a beat with two ends and two starts, which closes the old packet, carries a complete one, and opens another, which a final end-only beat closes. Stalling the consumer while the next beat waits covers the hold path. Each error rule is then hit from a clean reset, so the sticky bit can be traced to one cause.

// File: rtl/cpl_seg_pkg.sv
package cpl_seg_pkg;
   localparam int DEF_DATA_W = 512;
   localparam int DEF_SLOTS  = 4;
   localparam int DWORD_W    = 32;
   localparam int MAX_SLOTS  = 8;

   function automatic int count_ones(input logic [MAX_SLOTS-1:0] v);
      int n;
      n = 0;
      for (int i = 0; i < MAX_SLOTS; i++) n += int'(v[i]);
      return n;
   endfunction

   function automatic logic is_thermo(input logic [MAX_SLOTS-1:0] v);
      return ((v & (v + 1'b1)) == '0);
   endfunction
endpackage

// File: rtl/cpl_seg_flag_check.sv
module cpl_seg_flag_check
   import cpl_seg_pkg::*;
#(
   parameter int SLOTS = DEF_SLOTS,
   parameter int PTR_W = $clog2(SLOTS),
   parameter int CNT_W = $clog2(SLOTS + 2)
) (
   input  logic [SLOTS-1:0]       sop_flags,
   input  logic [SLOTS*PTR_W-1:0] sop_ptr,
   input  logic [SLOTS-1:0]       eop_flags,
   output logic [CNT_W-1:0]       n_sop,
   output logic [CNT_W-1:0]       n_eop,
   output logic                   code_err
);
   logic [SLOTS-1:0] ptr_bad;

   generate
      for (genvar i = 0; i < SLOTS; i++) begin : g_ptr
         // R8: start slot i may not sit on a lane below i
         assign ptr_bad[i] = sop_flags[i] &&
                             (int'(sop_ptr[i*PTR_W +: PTR_W]) < i);
      end
   endgenerate

   always_comb begin
      logic [MAX_SLOTS-1:0] s_ext, e_ext;
      s_ext = MAX_SLOTS'(sop_flags);
      e_ext = MAX_SLOTS'(eop_flags);
      n_sop = CNT_W'(count_ones(s_ext));
      n_eop = CNT_W'(count_ones(e_ext));
      // R7: non-thermometer flag vectors are reserved
      code_err = !is_thermo(s_ext) || !is_thermo(e_ext) || (|ptr_bad);
   end
endmodule

// File: rtl/cpl_seg_build.sv
module cpl_seg_build #(
   parameter int SLOTS  = 4,
   parameter int DWORDS = 16,
   parameter int PTR_W  = $clog2(SLOTS),
   parameter int IDX_W  = $clog2(DWORDS),
   parameter int CNT_W  = $clog2(SLOTS + 2)
) (
   input  logic                   open_q,
   input  logic [SLOTS*PTR_W-1:0] sop_ptr,
   input  logic [SLOTS*IDX_W-1:0] eop_ptr,
   input  logic [CNT_W-1:0]       n_sop,
   input  logic [CNT_W-1:0]       n_eop,
   output logic [SLOTS-1:0]       mask,
   output logic [SLOTS*IDX_W-1:0] first,
   output logic [SLOTS*IDX_W-1:0] last,
   output logic [SLOTS-1:0]       is_sop,
   output logic [SLOTS-1:0]       is_eop,
   output logic                   pair_err,
   output logic                   open_next
);
   localparam int LANE_DW = DWORDS / SLOTS;

   logic [CNT_W-1:0] n_seg;
   logic [SLOTS-1:0] order_bad;

   assign n_seg = n_sop + CNT_W'(open_q);

   generate
      for (genvar k = 0; k < SLOTS; k++) begin : g_slot
         logic [PTR_W-1:0] sp;
         logic [IDX_W-1:0] ep;
         if (k == 0) begin : g_first
            assign sp = sop_ptr[0 +: PTR_W];
         end else begin : g_rest
            // a continuation shifts start slots one segment up
            assign sp = open_q ? sop_ptr[(k-1)*PTR_W +: PTR_W]
                               : sop_ptr[k*PTR_W +: PTR_W];
         end
         assign ep        = eop_ptr[k*IDX_W +: IDX_W];
         assign mask[k]   = CNT_W'(k) < n_seg;
         assign is_sop[k] = mask[k] && !(open_q && (k == 0));
         assign is_eop[k] = mask[k] && (CNT_W'(k) < n_eop);
         assign first[k*IDX_W +: IDX_W] =
            is_sop[k] ? IDX_W'(int'(sp) * LANE_DW) : '0;
         assign last[k*IDX_W +: IDX_W] =
            is_eop[k] ? ep : (mask[k] ? IDX_W'(DWORDS - 1) : '0);
         // R9: an end before its own start is illegal
         assign order_bad[k] = is_sop[k] && is_eop[k] &&
                               (ep < IDX_W'(int'(sp) * LANE_DW));
      end
   endgenerate

   // R10: only the last segment may stay open
   assign pair_err  = (|order_bad) || (n_seg > CNT_W'(SLOTS)) ||
                      (n_eop > n_seg) || (n_seg > n_eop + 1'b1);
   assign open_next = n_seg > n_eop;
endmodule

// File: rtl/cpl_seg_out_stage.sv
module cpl_seg_out_stage #(
   parameter int SLOTS = 4,
   parameter int IDX_W = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   output logic                   in_ready,
   input  logic [SLOTS-1:0]       d_mask,
   input  logic [SLOTS*IDX_W-1:0] d_first,
   input  logic [SLOTS*IDX_W-1:0] d_last,
   input  logic [SLOTS-1:0]       d_sop,
   input  logic [SLOTS-1:0]       d_eop,
   input  logic                   d_err,
   input  logic                   d_open,
   output logic                   open_q,
   output logic                   out_valid,
   input  logic                   out_ready,
   output logic [SLOTS-1:0]       q_mask,
   output logic [SLOTS*IDX_W-1:0] q_first,
   output logic [SLOTS*IDX_W-1:0] q_last,
   output logic [SLOTS-1:0]       q_sop,
   output logic [SLOTS-1:0]       q_eop,
   output logic                   err_q
);
   logic take;

   assign in_ready = !out_valid || out_ready;
   assign take     = in_valid && in_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         open_q    <= 1'b0;
         err_q     <= 1'b0;
         q_mask    <= '0;
         q_first   <= '0;
         q_last    <= '0;
         q_sop     <= '0;
         q_eop     <= '0;
      end else if (take) begin
         out_valid <= 1'b1;
         open_q    <= d_open;
         err_q     <= err_q | d_err;
         q_mask    <= d_mask;
         q_first   <= d_first;
         q_last    <= d_last;
         q_sop     <= d_sop;
         q_eop     <= d_eop;
      end else if (out_ready) begin
         out_valid <= 1'b0;
      end
   end

   a_r1_accept_shows: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready |=> out_valid);
   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(q_mask) &&
      $stable(q_first) && $stable(q_last) && $stable(q_sop) && $stable(q_eop));
   a_r2_no_ready: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |-> !in_ready);
   a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |=> err_q);
endmodule

// File: rtl/cpl_seg_decoder.sv
module cpl_seg_decoder
   import cpl_seg_pkg::*;
#(
   parameter  int DATA_W = DEF_DATA_W,
   parameter  int SLOTS  = DEF_SLOTS,
   localparam int DWORDS = DATA_W / DWORD_W,
   localparam int PTR_W  = $clog2(SLOTS),
   localparam int IDX_W  = $clog2(DWORDS),
   localparam int CNT_W  = $clog2(SLOTS + 2)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   output logic                   in_ready,
   input  logic [SLOTS-1:0]       in_sop_flags,
   input  logic [SLOTS*PTR_W-1:0] in_sop_ptr,
   input  logic [SLOTS-1:0]       in_eop_flags,
   input  logic [SLOTS*IDX_W-1:0] in_eop_ptr,
   output logic                   out_valid,
   input  logic                   out_ready,
   output logic [SLOTS-1:0]       seg_mask,
   output logic [SLOTS*IDX_W-1:0] seg_first,
   output logic [SLOTS*IDX_W-1:0] seg_last,
   output logic [SLOTS-1:0]       seg_sop,
   output logic [SLOTS-1:0]       seg_eop,
   output logic                   proto_err
);
   generate
      if (DATA_W % DWORD_W != 0) begin : g_bad_width
         $error("DATA_W must be a whole number of Dwords");
      end
      if ((SLOTS < 1) || (SLOTS > MAX_SLOTS) || ((1 << PTR_W) != SLOTS)) begin : g_bad_slots
         $error("SLOTS must be a power of two up to MAX_SLOTS");
      end
      if ((DWORDS % SLOTS != 0) || ((1 << IDX_W) != DWORDS)) begin : g_bad_lanes
         $error("Dword count must be a power of two divisible by SLOTS");
      end
   endgenerate

   logic [CNT_W-1:0]       n_sop, n_eop;
   logic                   code_err, pair_err, open_next, open_q;
   logic [SLOTS-1:0]       b_mask, b_sop, b_eop;
   logic [SLOTS*IDX_W-1:0] b_first, b_last;

   cpl_seg_flag_check #(.SLOTS(SLOTS), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_check (
      .sop_flags (in_sop_flags),
      .sop_ptr   (in_sop_ptr),
      .eop_flags (in_eop_flags),
      .n_sop     (n_sop),
      .n_eop     (n_eop),
      .code_err  (code_err)
   );

   cpl_seg_build #(.SLOTS(SLOTS), .DWORDS(DWORDS), .PTR_W(PTR_W),
                   .IDX_W(IDX_W), .CNT_W(CNT_W)) u_build (
      .open_q    (open_q),
      .sop_ptr   (in_sop_ptr),
      .eop_ptr   (in_eop_ptr),
      .n_sop     (n_sop),
      .n_eop     (n_eop),
      .mask      (b_mask),
      .first     (b_first),
      .last      (b_last),
      .is_sop    (b_sop),
      .is_eop    (b_eop),
      .pair_err  (pair_err),
      .open_next (open_next)
   );

   cpl_seg_out_stage #(.SLOTS(SLOTS), .IDX_W(IDX_W)) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .d_mask    (b_mask),
      .d_first   (b_first),
      .d_last    (b_last),
      .d_sop     (b_sop),
      .d_eop     (b_eop),
      .d_err     (code_err | pair_err),
      .d_open    (open_next),
      .open_q    (open_q),
      .out_valid (out_valid),
      .out_ready (out_ready),
      .q_mask    (seg_mask),
      .q_first   (seg_first),
      .q_last    (seg_last),
      .q_sop     (seg_sop),
      .q_eop     (seg_eop),
      .err_q     (proto_err)
   );

   a_r3_mask_contig: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ((seg_mask & (seg_mask + 1'b1)) == '0));
   a_r5_eop_in_mask: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ((seg_eop & ~seg_mask) == '0) && ((seg_sop & ~seg_mask) == '0));
   a_r6_cont_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && seg_mask[0] && !seg_sop[0] |-> seg_first[IDX_W-1:0] == '0);
   a_r6_only_first_cont: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (seg_sop | {{(SLOTS-1){1'b0}}, 1'b1} | ~seg_mask) == '1);
endmodule

// File: tb/cpl_seg_decoder_test.sv
module cpl_seg_decoder_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [3:0]  in_sop_flags = '0;
   logic [7:0]  in_sop_ptr = '0;
   logic [3:0]  in_eop_flags = '0;
   logic [15:0] in_eop_ptr = '0;
   logic        out_valid;
   logic        out_ready = 1'b1;
   logic [3:0]  seg_mask, seg_sop, seg_eop;
   logic [15:0] seg_first, seg_last;
   logic        proto_err;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;

   always #10 clk = ~clk;

   cpl_seg_decoder uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_sop_flags(in_sop_flags), .in_sop_ptr(in_sop_ptr),
      .in_eop_flags(in_eop_flags), .in_eop_ptr(in_eop_ptr),
      .out_valid(out_valid), .out_ready(out_ready), .seg_mask(seg_mask),
      .seg_first(seg_first), .seg_last(seg_last), .seg_sop(seg_sop),
      .seg_eop(seg_eop), .proto_err(proto_err)
   );

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // drive one beat at a falling edge; outputs are checked at the next falling edge
   task automatic beat(input logic [3:0] sf, input logic [7:0] sp,
                       input logic [3:0] ef, input logic [15:0] ep);
      @(negedge clk);
      in_sop_flags = sf; in_sop_ptr = sp; in_eop_flags = ef; in_eop_ptr = ep;
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic expect_seg(input string tag, input logic [3:0] m,
                             input logic [15:0] f, input logic [15:0] l,
                             input logic [3:0] s, input logic [3:0] e);
      chk({tag, " valid"}, 32'(out_valid), 32'd1);
      chk({tag, " mask"},  32'(seg_mask),  32'(m));
      chk({tag, " first"}, 32'(seg_first), 32'(f));
      chk({tag, " last"},  32'(seg_last),  32'(l));
      chk({tag, " sop"},   32'(seg_sop),   32'(s));
      chk({tag, " eop"},   32'(seg_eop),   32'(e));
   endtask

   task automatic t_reset();
      do_reset();
      chk("R11 reset out_valid", 32'(out_valid), 32'd0);
      chk("R11 reset proto_err", 32'(proto_err), 32'd0);
      chk("R1 reset in_ready", 32'(in_ready), 32'd1);
   endtask

   task automatic t_single();
      beat(4'b0001, 8'h00, 4'b0001, 16'h0007);
      expect_seg("R4 R5 single", 4'b0001, 16'h0000, 16'h0007, 4'b0001, 4'b0001);
      @(negedge clk);
      chk("R1 drains", 32'(out_valid), 32'd0);
   endtask

   task automatic t_four();
      beat(4'b1111, 8'hE4, 4'b1111, 16'hFB73);
      expect_seg("R3 R4 four", 4'b1111, 16'hC840, 16'hFB73, 4'b1111, 4'b1111);
   endtask

   task automatic t_open_chain();
      beat(4'b0001, 8'h02, 4'b0000, 16'h0000);
      expect_seg("R5 open start", 4'b0001, 16'h0008, 16'h000F, 4'b0001, 4'b0000);
      beat(4'b0000, 8'h00, 4'b0000, 16'h0000);
      expect_seg("R6 middle", 4'b0001, 16'h0000, 16'h000F, 4'b0000, 4'b0000);
      beat(4'b0011, 8'h0D, 4'b0011, 16'h0092);
      expect_seg("R6 R3 mixed", 4'b0111, 16'h0C40, 16'h0F92, 4'b0110, 4'b0011);
      beat(4'b0000, 8'h00, 4'b0001, 16'h0005);
      expect_seg("R6 close", 4'b0001, 16'h0000, 16'h0005, 4'b0000, 4'b0001);
      chk("R11 legal no err", 32'(proto_err), 32'd0);
   endtask

   task automatic t_backpressure();
      do_reset();
      @(negedge clk);
      out_ready = 1'b0;
      beat(4'b0001, 8'h00, 4'b0001, 16'h0007);
      in_sop_flags = 4'b1111; in_sop_ptr = 8'hE4;
      in_eop_flags = 4'b1111; in_eop_ptr = 16'hFB73; in_valid = 1'b1;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk("R2 stall ready", 32'(in_ready), 32'd0);
         expect_seg("R2 stall hold", 4'b0001, 16'h0000, 16'h0007, 4'b0001, 4'b0001);
      end
      out_ready = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      expect_seg("R1 after stall", 4'b1111, 16'hC840, 16'hFB73, 4'b1111, 4'b1111);
   endtask

   task automatic t_err(input string tag, input logic [3:0] sf, input logic [7:0] sp,
                        input logic [3:0] ef, input logic [15:0] ep);
      do_reset();
      beat(sf, sp, ef, ep);
      chk(tag, 32'(proto_err), 32'd1);
   endtask

   task automatic t_err_open();
      do_reset();
      beat(4'b0001, 8'h02, 4'b0000, 16'h0000);
      chk("R10 open ok", 32'(proto_err), 32'd0);
      beat(4'b0001, 8'h01, 4'b0000, 16'h0000);
      chk("R10 start while open", 32'(proto_err), 32'd1);
      do_reset();
      beat(4'b0011, 8'h04, 4'b0000, 16'h0000);
      chk("R10 two opens", 32'(proto_err), 32'd1);
      beat(4'b0001, 8'h00, 4'b0001, 16'h0003);
      chk("R11 sticky", 32'(proto_err), 32'd1);
   endtask

   initial begin
      t_reset();
      t_single();
      t_four();
      t_open_chain();
      t_backpressure();
      t_err("R7 sop code", 4'b0101, 8'h00, 4'b0000, 16'h0000);
      t_err("R7 eop code", 4'b0000, 8'h00, 4'b0010, 16'h0000);
      t_err("R8 sop ptr", 4'b0011, 8'h00, 4'b0011, 16'h00F3);
      t_err("R9 end before start", 4'b0001, 8'h02, 4'b0001, 16'h0003);
      t_err_open();
      if (!done) begin
         done = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      #(20 * 200000);
      if (!done) begin
         done = 1;
         n_cmp++; n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule